// File: doc/BRIEF.md
# Requester ID Mapping Translator

This block rewrites the identity fields of packets that cross a non-transparent bridge between two isolated address domains. It keeps a 16-entry mapping table. Each entry holds a bus/device/function (BDF) triple and a valid flag. For an address-routed request, the requester BDF is searched across all valid entries. The forwarded requester ID then names the far-side bridge endpoint's bus, and its device/function byte carries the matching entry's index. For a completion coming back the other way, that device/function byte is used directly as a table index. This recovers the original requester, and the completer ID is replaced with the BDF of the local endpoint, which transmits the completion.

Every packet gets a forward-or-drop decision one clock after it is presented. A request that matches nothing raises a sticky unsupported-request status bit. A completion that points at an empty or out-of-range slot raises a separate sticky status bit. Software writes the table through a single write port and clears status bits by writing ones.

Top module: `rid_xlat`

## Requirements
- R1: After synchronous reset, out_valid is 0, both status bits are 0, and every table entry is invalid, so any request is dropped until the table is written.
- R2: A request (in_is_cpl=0) that matches a valid entry is forwarded. Its requester ID is {remote_bdf[15:8], 8'(index)}, and its completer ID passes through unchanged. The ID layout is bus in [15:8], device in [7:3] and function in [2:0].
- R3: When several valid entries hold the requester BDF, the lowest index is used.
- R4: An entry whose valid flag is 0 never matches a request, even when its stored BDF equals the requester ID.
- R5: A request with no valid match is dropped with both IDs unchanged, and status bit 0 (unsupported request) is set.
- R6: A completion (in_is_cpl=1) whose device/function byte in_req_id[7:0] indexes a valid entry is forwarded. Its requester ID becomes that entry's BDF, and its completer ID becomes local_bdf.
- R7: A completion whose device/function byte is greater than 15, or that indexes an invalid entry, is dropped with both IDs unchanged, and status bit 1 is set.
- R8: Status bits are sticky. Writing 1 to sts_clr[i] clears bit i. A new error event in the same cycle as its clear leaves the bit set.
- R9: A table write takes effect on the next cycle. A lookup presented in the same cycle as the write sees the previous contents.
- R10: out_valid follows in_valid with one cycle of latency, and when out_valid is 1 exactly one of out_fwd and out_drop is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet header present this cycle |
| in_is_cpl | input | 1 | 1 = completion, 0 = address-routed request |
| in_req_id | input | 16 | Incoming requester ID |
| in_cpl_id | input | 16 | Incoming completer ID |
| local_bdf | input | 16 | BDF of the endpoint that owns this table |
| remote_bdf | input | 16 | BDF of the endpoint on the far side |
| tbl_we | input | 1 | Table write strobe |
| tbl_widx | input | 4 | Entry to write |
| tbl_wvld | input | 1 | Valid flag to store |
| tbl_wbdf | input | 16 | BDF to store |
| sts_clr | input | 2 | Write-one-to-clear for status bits |
| out_valid | output | 1 | Result present |
| out_fwd | output | 1 | Packet is forwarded |
| out_drop | output | 1 | Packet is dropped |
| out_req_id | output | 16 | Rewritten requester ID |
| out_cpl_id | output | 16 | Rewritten completer ID |
| sts | output | 2 | Bit 0 unsupported request, bit 1 bad completion index |

## Verification
Two pairs of functions can land in the same clock. The first pair is a table write and a lookup against the entry being written. The bench provokes it by writing a fresh BDF and presenting a request for that BDF in the same cycle. It expects a drop, then a forward on the following cycle. The second pair is a status clear and a new error of the same kind. The bench provokes it by presenting a failing request together with sts_clr[0] while bit 0 is already set, and judges that the bit stays set. Random traffic also mixes writes, clears and packets freely, and a bench model predicts every outcome.

// File: rtl/rid_xlat_pkg.sv
package rid_xlat_pkg;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } bdf_t;

    typedef struct packed {
        logic vld;
        bdf_t bdf;
    } map_entry_t;

    typedef enum logic [1:0] {
        ST_UR      = 2'd0,
        ST_BAD_CPL = 2'd1
    } sts_bit_e;

    localparam int STS_W = 2;

    function automatic logic [7:0] devfn_of(input bdf_t b);
        return {b.dev, b.fn};
    endfunction

    function automatic bdf_t make_bdf(input logic [7:0] bus, input logic [7:0] devfn);
        bdf_t r;
        r.bus = bus;
        r.dev = devfn[7:3];
        r.fn  = devfn[2:0];
        return r;
    endfunction

endpackage

// File: rtl/rid_xlat_table.sv
module rid_xlat_table
    import rid_xlat_pkg::*;
#(
    parameter int N_ENTRY = 16,
    localparam int IDX_W = $clog2(N_ENTRY)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  map_entry_t                wentry,
    output map_entry_t [N_ENTRY-1:0]  entries
);

    map_entry_t [N_ENTRY-1:0] mem_q;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                mem_q[g] <= wentry;
            end
        end
    end

    assign entries = mem_q;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (!rst && we) |=> (mem_q[$past(widx)] == $past(wentry))) // R9
        else $error("table write not visible next cycle");

endmodule

// File: rtl/rid_xlat_match.sv
module rid_xlat_match
    import rid_xlat_pkg::*;
#(
    parameter int N_ENTRY = 16,
    localparam int IDX_W = $clog2(N_ENTRY)
) (
    input  map_entry_t [N_ENTRY-1:0] entries,
    input  bdf_t                     key,
    output logic                     hit,
    output logic [IDX_W-1:0]         hit_idx
);

    logic [N_ENTRY-1:0] hit_vec;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign hit_vec[g] = entries[g].vld && (entries[g].bdf == key);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (hit) begin
            AST_HIT_IS_VALID: assert (entries[hit_idx].vld && entries[hit_idx].bdf == key) // R4
                else $error("hit on an invalid or different entry");
            AST_HIT_LOWEST: assert ((hit_vec & ~({N_ENTRY{1'b1}} << hit_idx)) == '0) // R3
                else $error("a lower matching entry was skipped");
        end
    end

endmodule

// File: rtl/rid_xlat_status.sv
module rid_xlat_status
    import rid_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] set_evt,
    input  logic [STS_W-1:0] clr_w1c,
    output logic [STS_W-1:0] sts
);

    logic [STS_W-1:0] sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_w1c) | set_evt;
        end
    end

    assign sts = sts_q;

    for (genvar b = 0; b < STS_W; b++) begin : g_chk
        AST_STS_HOLD: assert property (@(posedge clk) disable iff (rst)
            (sts_q[b] && !clr_w1c[b]) |=> sts_q[b]) // R8
            else $error("sticky status bit lost");
        AST_STS_SET: assert property (@(posedge clk) disable iff (rst)
            (!rst && set_evt[b]) |=> sts_q[b]) // R8
            else $error("status event not recorded");
    end

endmodule

// File: rtl/rid_xlat.sv
module rid_xlat
    import rid_xlat_pkg::*;
#(
    parameter int N_ENTRY = 16,
    localparam int IDX_W = $clog2(N_ENTRY)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_is_cpl,
    input  logic [15:0] in_req_id,
    input  logic [15:0] in_cpl_id,
    input  logic [15:0] local_bdf,
    input  logic [15:0] remote_bdf,
    input  logic        tbl_we,
    input  logic [3:0]  tbl_widx,
    input  logic        tbl_wvld,
    input  logic [15:0] tbl_wbdf,
    input  logic [1:0]  sts_clr,
    output logic        out_valid,
    output logic        out_fwd,
    output logic        out_drop,
    output logic [15:0] out_req_id,
    output logic [15:0] out_cpl_id,
    output logic [1:0]  sts
);

    map_entry_t [N_ENTRY-1:0] entries;
    map_entry_t               wentry;
    bdf_t                     req_key;
    logic                     req_hit;
    logic [IDX_W-1:0]         req_idx;
    logic [7:0]               cpl_devfn;
    logic                     cpl_in_range;
    logic                     cpl_ok;
    map_entry_t               cpl_entry;
    logic                     fwd_d;
    bdf_t                     rid_d;
    bdf_t                     cid_d;
    logic [STS_W-1:0]         set_evt;

    logic                     valid_q;
    logic                     fwd_q;
    logic                     cpl_q;
    bdf_t                     rid_q;
    bdf_t                     cid_q;

    assign wentry.vld = tbl_wvld;
    assign wentry.bdf = bdf_t'(tbl_wbdf);

    rid_xlat_table #(.N_ENTRY(N_ENTRY)) u_table (
        .clk     (clk),
        .rst     (rst),
        .we      (tbl_we),
        .widx    (tbl_widx[IDX_W-1:0]),
        .wentry  (wentry),
        .entries (entries)
    );

    assign req_key = bdf_t'(in_req_id);

    rid_xlat_match #(.N_ENTRY(N_ENTRY)) u_match (
        .entries (entries),
        .key     (req_key),
        .hit     (req_hit),
        .hit_idx (req_idx)
    );

    // completion path: device/function byte is a direct table index
    assign cpl_devfn    = devfn_of(req_key);
    assign cpl_in_range = 32'(cpl_devfn) < N_ENTRY;
    assign cpl_entry    = entries[cpl_devfn[IDX_W-1:0]];
    assign cpl_ok       = cpl_in_range && cpl_entry.vld;

    always_comb begin
        rid_d = bdf_t'(in_req_id);
        cid_d = bdf_t'(in_cpl_id);
        fwd_d = 1'b0;
        set_evt = '0;
        if (in_is_cpl) begin
            if (cpl_ok) begin
                fwd_d = 1'b1;
                rid_d = cpl_entry.bdf;
                cid_d = bdf_t'(local_bdf);
            end else begin
                set_evt[ST_BAD_CPL] = in_valid;
            end
        end else begin
            if (req_hit) begin
                fwd_d = 1'b1;
                rid_d = make_bdf(remote_bdf[15:8], 8'(req_idx));
            end else begin
                set_evt[ST_UR] = in_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            fwd_q   <= 1'b0;
            cpl_q   <= 1'b0;
            rid_q   <= '0;
            cid_q   <= '0;
        end else begin
            valid_q <= in_valid;
            fwd_q   <= in_valid && fwd_d;
            cpl_q   <= in_is_cpl;
            rid_q   <= rid_d;
            cid_q   <= cid_d;
        end
    end

    rid_xlat_status u_status (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .clr_w1c (sts_clr),
        .sts     (sts)
    );

    assign out_valid  = valid_q;
    assign out_fwd    = valid_q && fwd_q;
    assign out_drop   = valid_q && !fwd_q;
    assign out_req_id = rid_q;
    assign out_cpl_id = cid_q;

    AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_fwd ^ out_drop)) // R10
        else $error("forward and drop not exclusive");
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid) |=> out_valid) // R10
        else $error("result missing one cycle after input");
    AST_REQ_BUS: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && !in_is_cpl && req_hit) |=> (out_fwd && out_req_id[15:8] == $past(remote_bdf[15:8]))) // R2
        else $error("forwarded request does not carry far-side bus");
    AST_CPL_CID: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_is_cpl && cpl_ok) |=> (out_fwd && out_cpl_id == $past(local_bdf))) // R6
        else $error("completer ID not replaced by local endpoint");
    AST_CPL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (!rst && in_valid && in_is_cpl && !cpl_in_range) |=> (out_drop && sts[ST_BAD_CPL])) // R7
        else $error("out-of-range completion not dropped");

endmodule

// File: tb/rid_xlat_bench.sv
module rid_xlat_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_is_cpl;
    logic [15:0] in_req_id;
    logic [15:0] in_cpl_id;
    logic [15:0] local_bdf;
    logic [15:0] remote_bdf;
    logic        tbl_we;
    logic [3:0]  tbl_widx;
    logic        tbl_wvld;
    logic [15:0] tbl_wbdf;
    logic [1:0]  sts_clr;
    logic        out_valid;
    logic        out_fwd;
    logic        out_drop;
    logic [15:0] out_req_id;
    logic [15:0] out_cpl_id;
    logic [1:0]  sts;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        ref_vld [16];
    logic [15:0] ref_bdf [16];
    logic [1:0]  ref_sts;

    always #10 clk = ~clk;

    rid_xlat u_rid_xlat (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_is_cpl(in_is_cpl),
        .in_req_id(in_req_id), .in_cpl_id(in_cpl_id), .local_bdf(local_bdf),
        .remote_bdf(remote_bdf), .tbl_we(tbl_we), .tbl_widx(tbl_widx),
        .tbl_wvld(tbl_wvld), .tbl_wbdf(tbl_wbdf), .sts_clr(sts_clr),
        .out_valid(out_valid), .out_fwd(out_fwd), .out_drop(out_drop),
        .out_req_id(out_req_id), .out_cpl_id(out_cpl_id), .sts(sts)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after a falling edge, predict, check at the next falling edge
    task automatic step(input string tag, input logic v, input logic cpl,
                        input logic [15:0] rid, input logic [15:0] cid,
                        input logic we, input logic [3:0] widx, input logic wv,
                        input logic [15:0] wbdf, input logic [1:0] clr);
        logic        e_fwd;
        logic [15:0] e_rid;
        logic [15:0] e_cid;
        logic [1:0]  e_set;
        string       t;
        int          df;
        e_fwd = 1'b0; e_rid = rid; e_cid = cid; e_set = 2'b00; t = tag;
        if (!cpl) begin
            for (int i = 15; i >= 0; i--)
                if (ref_vld[i] && ref_bdf[i] == rid) begin
                    e_fwd = 1'b1;
                    e_rid = {remote_bdf[15:8], 8'(i)};
                end
            if (!e_fwd) e_set[0] = v;
            if (t == "") t = e_fwd ? "R2" : "R5";
        end else begin
            df = int'(rid[7:0]);
            if (df < 16 && ref_vld[df]) begin
                e_fwd = 1'b1;
                e_rid = ref_bdf[df];
                e_cid = local_bdf;
            end else begin
                e_set[1] = v;
            end
            if (t == "") t = e_fwd ? "R6" : "R7";
        end
        ref_sts = (ref_sts & ~clr) | e_set;
        in_valid = v; in_is_cpl = cpl; in_req_id = rid; in_cpl_id = cid;
        tbl_we = we; tbl_widx = widx; tbl_wvld = wv; tbl_wbdf = wbdf; sts_clr = clr;
        if (we) begin
            ref_vld[widx] = wv;
            ref_bdf[widx] = wbdf;
        end
        @(negedge clk);
        chk("R10", "out_valid", int'(out_valid), int'(v));
        if (v) begin
            chk("R10", "fwd^drop", int'(out_fwd ^ out_drop), 1);
            chk(t, "out_fwd", int'(out_fwd), int'(e_fwd));
            chk(t, "out_req_id", int'(out_req_id), int'(e_rid));
            chk(t, "out_cpl_id", int'(out_cpl_id), int'(e_cid));
        end
        chk("R8", "sts", int'(sts), int'(ref_sts));
    endtask

    task automatic idle();
        step("", 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
    endtask

    task automatic wr(input logic [3:0] idx, input logic vld, input logic [15:0] b);
        step("", 1'b0, 1'b0, 16'h0, 16'h0, 1'b1, idx, vld, b, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pool [6];
        void'($urandom(32'd20240611));
        pool[0] = 16'h0108; pool[1] = 16'h0310; pool[2] = 16'h0420;
        pool[3] = 16'h0777; pool[4] = 16'h2211; pool[5] = 16'h00FF;
        for (int i = 0; i < 16; i++) begin ref_vld[i] = 1'b0; ref_bdf[i] = 16'h0; end
        ref_sts = 2'b00;
        local_bdf = 16'h0500;   // 5,0,0
        remote_bdf = 16'h0600;  // 6,0,0
        rst = 1'b1;
        in_valid = 0; in_is_cpl = 0; in_req_id = 0; in_cpl_id = 0;
        tbl_we = 0; tbl_widx = 0; tbl_wvld = 0; tbl_wbdf = 0; sts_clr = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "sts", int'(sts), 0);
        rst = 1'b0;
        // R1: empty table drops any request
        step("R1", 1'b1, 1'b0, 16'h0108, 16'h0000, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        step("R8", 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 4'h0, 1'b0, 16'h0, 2'b01);
        // R2 / R6: table holds 1,1,0 at index 0
        wr(4'd0, 1'b1, 16'h0108);
        step("R2", 1'b1, 1'b0, 16'h0108, 16'h1234, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        step("R6", 1'b1, 1'b1, 16'h0600, 16'h0210, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        // R4: invalid entry with matching BDF
        wr(4'd2, 1'b0, 16'h0310);
        step("R4", 1'b1, 1'b0, 16'h0310, 16'h0000, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        step("R7", 1'b1, 1'b1, 16'h0602, 16'h0210, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        // R3: duplicates at 7 and 3 -> index 3
        wr(4'd7, 1'b1, 16'h0420);
        wr(4'd3, 1'b1, 16'h0420);
        step("R3", 1'b1, 1'b0, 16'h0420, 16'h0000, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        // R7: index boundary 15 in range, 16 and 20 out of range
        wr(4'd15, 1'b1, 16'h2211);
        step("R6", 1'b1, 1'b1, 16'h060F, 16'h0210, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        step("R7", 1'b1, 1'b1, 16'h0610, 16'h0210, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        step("R7", 1'b1, 1'b1, 16'h0614, 16'h0210, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        // R8: error together with its clear keeps the bit
        step("R8", 1'b1, 1'b0, 16'h0BAD, 16'h0000, 1'b0, 4'h0, 1'b0, 16'h0, 2'b01);
        step("R8", 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 4'h0, 1'b0, 16'h0, 2'b11);
        chk("R8", "sts cleared", int'(sts), 0);
        // R9: write and lookup of the same BDF in one cycle
        step("R9", 1'b1, 1'b0, 16'h0777, 16'h0000, 1'b1, 4'd5, 1'b1, 16'h0777, 2'b00);
        step("R9", 1'b1, 1'b0, 16'h0777, 16'h0000, 1'b0, 4'h0, 1'b0, 16'h0, 2'b00);
        chk("R9", "new index", int'(out_req_id), 16'h0605);
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [15:0] rid;
            r = int'($urandom_range(0, 99));
            if (r < 15) begin
                wr(4'($urandom_range(0, 15)), logic'($urandom_range(0, 3) != 0),
                   pool[$urandom_range(0, 5)]);
            end else if (r < 60) begin
                rid = pool[$urandom_range(0, 5)];
                step("", 1'b1, 1'b0, rid, 16'($urandom), 1'b0, 4'h0, 1'b0, 16'h0,
                     2'($urandom_range(0, 3) == 0 ? $urandom_range(0, 3) : 0));
            end else if (r < 90) begin
                rid = {8'($urandom), 8'($urandom_range(0, 19))};
                step("", 1'b1, 1'b1, rid, 16'($urandom),
                     logic'($urandom_range(0, 9) == 0), 4'($urandom_range(0, 15)),
                     1'b1, pool[$urandom_range(0, 5)], 2'b00);
            end else begin
                step("", 1'b0, 1'b0, 16'h0, 16'h0, 1'b0, 4'h0, 1'b0, 16'h0,
                     2'($urandom_range(0, 3)));
            end
        end
        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule